// File: doc/BRIEF.md
# Vector Lane Exchange Stage

This block sits between register read and execute in a vector datapath. It takes one 160-bit operand line and reorders its lanes before the arithmetic units see them. The line can be viewed as eight 20-bit half-word lanes or as four 40-bit word lanes, where a 40-bit lane may hold a complex value made of two signed 20-bit parts. Every result is registered, so the stage adds one cycle of latency. A valid bit travels with the data.

A per-instruction exchange flag turns the stage on. When the flag is clear, the operand passes through unchanged; this covers scalar operations and plain vector operations. When the flag is set, a mode code picks one of several operations. General shuffle routes lanes through a multistage shuffle-exchange network, and each input lane carries its own destination tag. Sample shift slides the four word lanes up by one position and inserts a fresh 40-bit sample at the bottom, which suits a complex FIR filter that takes one new sample per pass. Three fixed butterfly reorderings let the three passes of an 8-point FFT run back to back with no intermediate storage.

Top module: `lx_exchange_stage`

## Requirements
- R1: While `xchg_en` is 0, a valid input line reaches `out_data` unchanged, whatever the values of `mode`, `word_gran` and `lane_tags`.
- R2: With `xchg_en` at 1, the mode codes 5, 6 and 7 are reserved and pass the line through unchanged.
- R3: Mode 0 with `word_gran`=0 is a half-word shuffle. Tag field `lane_tags[3i+2:3i]` gives the destination of input half lane i, which occupies bits [20i+19:20i]. For tag sets the network can route (identity and any cyclic rotation), output lane `tag_i` equals input lane i.
- R4: Mode 0 with `word_gran`=1 is a word shuffle over the 40-bit lanes at bits [40i+39:40i]. The destination of word lane i is `lane_tags[2i+1:2i]`. Rotations and identity are delivered exactly.
- R5: When two sources ask for the same switch output in shuffle mode, the source with the lower lane index wins and the other is dropped. An output lane that no source reaches reads zero. For example, all tags at zero give lane 0 = input lane 0 and every other lane = 0.
- R6: Mode 1 (sample shift): word lane 0 of the output takes `new_sample`, word lane k (k=1..3) takes input word lane k-1, and input word lane 3 is discarded.
- R7: Mode 2 (first FFT pass): output half lane j takes input half lane bitreverse3(j). The output holds source lanes 0,4,2,6,1,5,3,7 in that order.
- R8: Mode 3 (second FFT pass): output half lane j takes the input lane whose index is j with bits 0 and 1 swapped, giving the order 0,2,1,3,4,6,5,7.
- R9: Mode 4 (third FFT pass): output half lane j takes the input lane whose index is j with bits 1 and 2 swapped, giving the order 0,1,4,5,2,3,6,7.
- R10: `out_valid` equals `in_valid` delayed by exactly one clock. The result of an input is on `out_data` in the same cycle as its `out_valid`.
- R11: In a cycle with `in_valid` at 0, `out_data` keeps its previous value and `out_valid` is 0.
- R12: While `rst_n` is low, and right after it, `out_valid` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand line present this cycle |
| xchg_en | input | 1 | Exchange flag; 0 selects pass-through |
| mode | input | 3 | 0 shuffle, 1 sample shift, 2/3/4 FFT passes, 5-7 reserved |
| word_gran | input | 1 | Shuffle granularity: 0 half-word, 1 word |
| lane_tags | input | 24 | Per-lane destination tags for shuffle |
| new_sample | input | 40 | Sample inserted into word lane 0 in shift mode |
| in_data | input | 160 | Operand line from register read |
| out_valid | output | 1 | Registered valid |
| out_data | output | 160 | Registered exchanged line |

## Verification
The bench runs shuffle rotations at both granularities. A network that reverses the order in which tag bits are consumed would send lanes to mirrored positions, and these tests would catch it. An all-zero tag set checks contention: a design that let the higher lane win, or that left a stale value on a lane no source reaches, produces a nonzero lane or the wrong survivor. Each of the three FFT patterns is compared lane by lane, because a swapped pass order changes which lanes move. Idle gaps with junk on the inputs check that the registered line holds and does not take the junk.

// File: rtl/lx_pkg.sv
package lx_pkg;

    typedef enum logic [2:0] {
        XM_SHUFFLE = 3'd0,
        XM_SHIFT   = 3'd1,
        XM_FFT_A   = 3'd2,
        XM_FFT_B   = 3'd3,
        XM_FFT_C   = 3'd4
    } xmode_e;

    localparam int FFT_PASSES = 3;

endpackage

// File: rtl/lx_omega.sv
// Shuffle-exchange network with destination-tag routing.
// Before every stage the positions rotate left by one bit; each 2x2 switch
// then steers an element by one tag bit, most significant bit first.
module lx_omega #(
    parameter int N = 8,
    parameter int W = 20,
    localparam int S = $clog2(N)
) (
    input  logic [N*W-1:0] din,
    input  logic [N*S-1:0] tags,
    output logic [N*W-1:0] dout
);

    logic         st_v [S+1][N];
    logic [W-1:0] st_d [S+1][N];
    logic [S-1:0] st_t [S+1][N];
    logic [S-1:0] st_s [S+1][N];

    function automatic int rotr(input int p);
        return (p >> 1) | ((p & 1) << (S - 1));
    endfunction

    always_comb begin
        for (int i = 0; i < N; i++) begin
            st_v[0][i] = 1'b1;
            st_d[0][i] = din[i*W +: W];
            st_t[0][i] = tags[i*S +: S];
            st_s[0][i] = S'(i);
        end
        for (int s = 0; s < S; s++) begin
            for (int k = 0; k < N/2; k++) begin
                for (int o = 0; o < 2; o++) begin
                    int  a;
                    int  b;
                    logic ua;
                    logic ub;
                    a  = rotr(2*k);
                    b  = rotr(2*k + 1);
                    ua = st_v[s][a] && (int'(st_t[s][a][S-1-s]) == o);
                    ub = st_v[s][b] && (int'(st_t[s][b][S-1-s]) == o);
                    if (ua && ub) begin
                        if (st_s[s][a] < st_s[s][b]) begin
                            st_v[s+1][2*k+o] = 1'b1;
                            st_d[s+1][2*k+o] = st_d[s][a];
                            st_t[s+1][2*k+o] = st_t[s][a];
                            st_s[s+1][2*k+o] = st_s[s][a];
                        end else begin
                            st_v[s+1][2*k+o] = 1'b1;
                            st_d[s+1][2*k+o] = st_d[s][b];
                            st_t[s+1][2*k+o] = st_t[s][b];
                            st_s[s+1][2*k+o] = st_s[s][b];
                        end
                    end else if (ua) begin
                        st_v[s+1][2*k+o] = 1'b1;
                        st_d[s+1][2*k+o] = st_d[s][a];
                        st_t[s+1][2*k+o] = st_t[s][a];
                        st_s[s+1][2*k+o] = st_s[s][a];
                    end else if (ub) begin
                        st_v[s+1][2*k+o] = 1'b1;
                        st_d[s+1][2*k+o] = st_d[s][b];
                        st_t[s+1][2*k+o] = st_t[s][b];
                        st_s[s+1][2*k+o] = st_s[s][b];
                    end else begin
                        st_v[s+1][2*k+o] = 1'b0;
                        st_d[s+1][2*k+o] = '0;
                        st_t[s+1][2*k+o] = '0;
                        st_s[s+1][2*k+o] = '0;
                    end
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            dout[i*W +: W] = st_v[S][i] ? st_d[S][i] : '0;
        end
    end

endmodule

// File: rtl/lx_fixed_perm.sv
// Hardwired FFT pass reordering: output lane j reads input lane SRC(j).
module lx_fixed_perm #(
    parameter int LANES = 8,
    parameter int W     = 20,
    parameter int PASS  = 0,
    localparam int B    = $clog2(LANES)
) (
    input  logic [LANES*W-1:0] din,
    output logic [LANES*W-1:0] dout
);

    function automatic int src_of(input int j);
        int r;
        r = 0;
        case (PASS)
            0: begin
                for (int b = 0; b < B; b++) r |= ((j >> b) & 1) << (B - 1 - b);
            end
            1: r = (j & ~3) | ((j & 1) << 1) | ((j >> 1) & 1);
            default: r = (j & ~6) | (((j >> 1) & 1) << 2) | (((j >> 2) & 1) << 1);
        endcase
        return r;
    endfunction

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam int SRC = src_of(j);
        assign dout[j*W +: W] = din[SRC*W +: W];
    end

endmodule

// File: rtl/lx_lane_shift.sv
// Slides word lanes up by one and inserts a fresh sample at lane 0.
module lx_lane_shift #(
    parameter int LANES = 4,
    parameter int LW    = 40
) (
    input  logic [(LANES-1)*LW-1:0] din_low,
    input  logic [LW-1:0]           sample,
    output logic [LANES*LW-1:0]     dout
);

    assign dout[LW-1:0] = sample;
    for (genvar k = 1; k < LANES; k++) begin : g_up
        assign dout[k*LW +: LW] = din_low[(k-1)*LW +: LW];
    end

endmodule

// File: rtl/lx_exchange_stage.sv
module lx_exchange_stage
    import lx_pkg::*;
#(
    parameter int HALF_W     = 20,
    parameter int HALF_LANES = 8,
    localparam int WORD_W     = 2 * HALF_W,
    localparam int WORD_LANES = HALF_LANES / 2,
    localparam int LINE_W     = HALF_W * HALF_LANES,
    localparam int HTAG_W     = $clog2(HALF_LANES),
    localparam int WTAG_W     = $clog2(WORD_LANES),
    localparam int TAGS_W     = HALF_LANES * HTAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              xchg_en,
    input  logic [2:0]        mode,
    input  logic              word_gran,
    input  logic [TAGS_W-1:0] lane_tags,
    input  logic [WORD_W-1:0] new_sample,
    input  logic [LINE_W-1:0] in_data,
    output logic              out_valid,
    output logic [LINE_W-1:0] out_data
);

    logic [LINE_W-1:0] shuf_half;
    logic [LINE_W-1:0] shuf_word;
    logic [LINE_W-1:0] shift_line;
    logic [LINE_W-1:0] fft_line [FFT_PASSES];
    logic [LINE_W-1:0] next_line;

    lx_omega #(.N(HALF_LANES), .W(HALF_W)) i_omega_half (
        .din  (in_data),
        .tags (lane_tags),
        .dout (shuf_half)
    );

    lx_omega #(.N(WORD_LANES), .W(WORD_W)) i_omega_word (
        .din  (in_data),
        .tags (lane_tags[WORD_LANES*WTAG_W-1:0]),
        .dout (shuf_word)
    );

    lx_lane_shift #(.LANES(WORD_LANES), .LW(WORD_W)) i_shift (
        .din_low (in_data[LINE_W-WORD_W-1:0]),
        .sample  (new_sample),
        .dout    (shift_line)
    );

    for (genvar p = 0; p < FFT_PASSES; p++) begin : g_fft
        lx_fixed_perm #(.LANES(HALF_LANES), .W(HALF_W), .PASS(p)) i_perm (
            .din  (in_data),
            .dout (fft_line[p])
        );
    end

    // Mode decode
    always_comb begin
        next_line = in_data;
        if (xchg_en) begin
            unique case (mode)
                XM_SHUFFLE: next_line = word_gran ? shuf_word : shuf_half;
                XM_SHIFT:   next_line = shift_line;
                XM_FFT_A:   next_line = fft_line[0];
                XM_FFT_B:   next_line = fft_line[1];
                XM_FFT_C:   next_line = fft_line[2];
                default:    next_line = in_data;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= next_line;
        end
    end

    a_r1_bypass_intact: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !xchg_en) |=> (out_data == $past(in_data)));

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    a_r6_sample_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && xchg_en && mode == XM_SHIFT)
        |=> (out_data[WORD_W-1:0] == $past(new_sample)));

    a_r7_fft_lane0_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && xchg_en && (mode == XM_FFT_A || mode == XM_FFT_B || mode == XM_FFT_C))
        |=> (out_data[HALF_W-1:0] == $past(in_data[HALF_W-1:0])));

endmodule

// File: tb/test_lx_exchange_stage.sv
`timescale 1ns/1ps
module test_lx_exchange_stage;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         xchg_en = 1'b0;
    logic [2:0]   mode = 3'd0;
    logic         word_gran = 1'b0;
    logic [23:0]  lane_tags = '0;
    logic [39:0]  new_sample = '0;
    logic [159:0] in_data = '0;
    logic         out_valid;
    logic [159:0] out_data;

    int checks = 0;
    int errors = 0;
    logic [159:0] exp_q [$];
    string        req_q [$];
    logic [159:0] last_out = '0;
    logic         mon_on = 1'b0;

    always #2 clk = ~clk;

    lx_exchange_stage i_lx_exchange_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .xchg_en(xchg_en),
        .mode(mode), .word_gran(word_gran), .lane_tags(lane_tags),
        .new_sample(new_sample), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [159:0] make_line(input int seed);
        logic [159:0] l;
        for (int i = 0; i < 8; i++) l[20*i +: 20] = 20'((seed << 8) | (i << 4) | 5);
        return l;
    endfunction

    function automatic logic [23:0] rot_tags(input int r, input logic gran);
        logic [23:0] t = '0;
        if (!gran) for (int i = 0; i < 8; i++) t[3*i +: 3] = 3'((i + r) % 8);
        else       for (int i = 0; i < 4; i++) t[2*i +: 2] = 2'((i + r) % 4);
        return t;
    endfunction

    function automatic logic [159:0] model(input logic fl, input logic [2:0] md,
            input logic gr, input logic [23:0] tg, input logic [39:0] ns,
            input logic [159:0] d);
        logic [159:0] o = '0;
        logic filled [8];
        int pa [8] = '{0,4,2,6,1,5,3,7};
        int pb [8] = '{0,2,1,3,4,6,5,7};
        int pc [8] = '{0,1,4,5,2,3,6,7};
        for (int i = 0; i < 8; i++) filled[i] = 1'b0;
        if (!fl) return d;
        case (md)
            3'd0: begin
                if (!gr) begin
                    for (int i = 0; i < 8; i++) begin
                        int t = int'(tg[3*i +: 3]);
                        if (!filled[t]) begin o[20*t +: 20] = d[20*i +: 20]; filled[t] = 1'b1; end
                    end
                end else begin
                    for (int i = 0; i < 4; i++) begin
                        int t = int'(tg[2*i +: 2]);
                        if (!filled[t]) begin o[40*t +: 40] = d[40*i +: 40]; filled[t] = 1'b1; end
                    end
                end
            end
            3'd1: begin
                o[39:0] = ns;
                for (int k = 1; k < 4; k++) o[40*k +: 40] = d[40*(k-1) +: 40];
            end
            3'd2: for (int j = 0; j < 8; j++) o[20*j +: 20] = d[20*pa[j] +: 20];
            3'd3: for (int j = 0; j < 8; j++) o[20*j +: 20] = d[20*pb[j] +: 20];
            3'd4: for (int j = 0; j < 8; j++) o[20*j +: 20] = d[20*pc[j] +: 20];
            default: o = d;
        endcase
        return o;
    endfunction

    task automatic send(input string req, input logic fl, input logic [2:0] md,
            input logic gr, input logic [23:0] tg, input logic [39:0] ns,
            input logic [159:0] d);
        @(negedge clk);
        in_valid = 1'b1; xchg_en = fl; mode = md; word_gran = gr;
        lane_tags = tg; new_sample = ns; in_data = d;
        exp_q.push_back(model(fl, md, gr, tg, ns, d));
        req_q.push_back(req);
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            in_valid = 1'b0; xchg_en = 1'b1; mode = 3'(c);
            in_data = make_line(900 + c); new_sample = 40'hDEAD0BEEF0;
        end
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                if (out_valid) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R10: got out_valid=1 expected 0 (nothing sent)");
                    end else begin
                        logic [159:0] e;
                        string r;
                        e = exp_q.pop_front();
                        r = req_q.pop_front();
                        if (out_data !== e) begin
                            errors++;
                            $display("FAIL %s: got %h expected %h", r, out_data, e);
                        end
                    end
                    last_out = out_data;
                end else begin
                    checks++;
                    if (out_data !== last_out) begin
                        errors++;
                        $display("FAIL R11: got %h expected %h (idle hold)", out_data, last_out);
                    end
                end
            end
        end
    end

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            errors++;
            $display("FAIL R12: got valid=%b data=%h expected 0 0", out_valid, out_data);
        end
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R1: pass-through with flag clear
        send("R1", 1'b0, 3'd0, 1'b0, 24'hFACE12, 40'h1, make_line(1));
        send("R1", 1'b0, 3'd2, 1'b1, 24'h000000, 40'h2, make_line(2));
        idle(2);
        // R3: half-word shuffle rotations
        send("R3", 1'b1, 3'd0, 1'b0, rot_tags(0, 1'b0), 40'h0, make_line(3));
        send("R3", 1'b1, 3'd0, 1'b0, rot_tags(3, 1'b0), 40'h0, make_line(4));
        send("R3", 1'b1, 3'd0, 1'b0, rot_tags(5, 1'b0), 40'h0, make_line(5));
        // R4: word shuffle rotations
        send("R4", 1'b1, 3'd0, 1'b1, rot_tags(1, 1'b1) | 24'hAB0000, 40'h0, make_line(6));
        send("R4", 1'b1, 3'd0, 1'b1, rot_tags(2, 1'b1), 40'h0, make_line(7));
        // R5: contention, lower lane wins, unreached lanes zero
        send("R5", 1'b1, 3'd0, 1'b0, 24'h000000, 40'h0, make_line(8));
        send("R5", 1'b1, 3'd0, 1'b1, 24'h000000, 40'h0, make_line(9));
        idle(1);
        // R6: sample shift, back to back
        send("R6", 1'b1, 3'd1, 1'b0, 24'h0, 40'h12345_6789A, make_line(10));
        send("R6", 1'b1, 3'd1, 1'b1, 24'h0, 40'hFEDCB_A9876, make_line(11));
        // R7, R8, R9: FFT passes
        send("R7", 1'b1, 3'd2, 1'b0, 24'h0, 40'h0, make_line(12));
        send("R8", 1'b1, 3'd3, 1'b0, 24'h0, 40'h0, make_line(13));
        send("R9", 1'b1, 3'd4, 1'b0, 24'h0, 40'h0, make_line(14));
        // R2: reserved codes
        send("R2", 1'b1, 3'd5, 1'b0, rot_tags(1, 1'b0), 40'h7, make_line(15));
        send("R2", 1'b1, 3'd7, 1'b1, rot_tags(2, 1'b0), 40'h8, make_line(16));
        idle(3);
        // R11 after a long gap, then R10 with one more item
        send("R10", 1'b1, 3'd2, 1'b0, 24'h0, 40'h0, make_line(17));
        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10: got %0d pending results expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule